// File: doc/BRIEF.md
# Flit-to-Packet Reassembly Ejector

This block serves the ejection side of one virtual channel in a network-on-chip interface. Flits arrive from the router's local output port one at a time. Each flit carries a type, a two-bit destination code and a payload. The block writes each payload into a packet register at the slot given by a running flit count. When the last flit of a packet arrives, the rebuilt packet is pushed into a small FIFO. The consuming controller sees a valid packet at the FIFO head and removes it with a one-cycle consumed strobe.

A response channel can be shared by a cache controller and a directory controller. For that case, a parameter tells the block which one it serves. The block then keeps only packets whose header flit names that consumer and drops the others. The router is stopped through a back-pressure output that rises while two FIFO slots are still free. Those two slots hold single-flit packets that are already in flight in the router crossbar and in this block's assembly stage.

Top module: `pkt_ejector`

## Requirements
- R1: Each valid flit payload is written into the packet slot selected by the flit count. The first flit of a packet lands in the least significant slot. Flits 0x20, 0x40, 0x60, 0x10 in that order give the packet 0x10604020 for 8-bit payloads and four slots.
- R2: Flit type encoding is 0 = HEAD, 1 = BODY, 2 = TAIL, 3 = HEAD_TAIL. A valid TAIL or HEAD_TAIL flit returns the count to zero and raises a one-cycle completion pulse. Any other valid flit advances the count.
- R3: The tail flit is sampled at clock edge k. The completed packet becomes visible on `pkt_valid_o` after edge k+1 and not before.
- R4: On a valid HEAD or HEAD_TAIL flit, the destination code is latched. Code 1 means cache controller, code 2 means directory controller, and any other code means neither.
- R5: With `SINK` = 1 (cache), only packets latched with code 1 are enqueued. With `SINK` = 2 (directory), only packets with code 2 are enqueued. With `SINK` = 0, every completed packet is enqueued.
- R6: A packet dropped by the destination filter still resets the flit count, so the next packet starts at slot 0.
- R7: `stop_o` is high exactly while the FIFO holds at least DEPTH-2 packets.
- R8: `pkt_valid_o` is high whenever the FIFO is not empty. `pkt_consumed_i` removes one packet. Packets leave in arrival order.
- R9: A consumed strobe while the FIFO is empty has no effect.
- R10: Reset (`rst_ni` low) clears the count, the destination flags, the packet register and the FIFO.
- R11: Slots not written by a shorter packet keep the values they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flit_valid_i | input | 1 | Incoming flit is valid this cycle |
| flit_type_i | input | 2 | Flit type (HEAD, BODY, TAIL, HEAD_TAIL) |
| flit_dest_i | input | 2 | Consumer code carried by header flits |
| flit_payload_i | input | PAYLOAD_W | Flit payload |
| pkt_valid_o | output | 1 | A rebuilt packet waits at the FIFO head |
| pkt_data_o | output | FLITS*PAYLOAD_W | Packet at the FIFO head |
| pkt_consumed_i | input | 1 | Consumer removes the head packet |
| stop_o | output | 1 | Back-pressure to the router |

## Verification
The bench builds three copies of the block side by side with SINK values 0, 1 and 2. All three see the same flit stream, so a single run shows each filter keeping or dropping the same packet. Every copy uses four 8-bit slots and a FIFO depth of four. With that depth, back-pressure rises at two entries and the FIFO fills after only four held single-flit packets. Holding the consumer shows the FIFO order, the full FIFO and the exact cycle a packet appears. Mixing packet lengths from one to four flits shows stale upper slots.

// File: rtl/ej_pkg.sv
package ej_pkg;
  typedef enum logic [1:0] {
    FT_HEAD = 2'd0,
    FT_BODY = 2'd1,
    FT_TAIL = 2'd2,
    FT_SOLO = 2'd3
  } ftype_e;

  localparam logic [1:0] DST_CACHE = 2'd1;
  localparam logic [1:0] DST_DIR   = 2'd2;

  localparam int unsigned SINK_ANY   = 0;
  localparam int unsigned SINK_CACHE = 1;
  localparam int unsigned SINK_DIR   = 2;
endpackage

// File: rtl/ej_assembler.sv
module ej_assembler
  import ej_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 8,
  parameter int unsigned FLITS     = 4,
  localparam int unsigned CW       = (FLITS > 1) ? $clog2(FLITS) : 1,
  localparam int unsigned PKT_W    = FLITS * PAYLOAD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flit_valid_i,
  input  logic [1:0]           flit_type_i,
  input  logic [1:0]           flit_dest_i,
  input  logic [PAYLOAD_W-1:0] flit_payload_i,
  output logic [PKT_W-1:0]     pkt_o,
  output logic                 done_o,
  output logic                 for_cache_o,
  output logic                 for_dir_o
);
  logic [FLITS-1:0][PAYLOAD_W-1:0] slots_q;
  logic [CW-1:0]                   cnt_q;
  logic                            is_last, is_first;

  assign is_last  = (flit_type_i == FT_TAIL) || (flit_type_i == FT_SOLO);
  assign is_first = (flit_type_i == FT_HEAD) || (flit_type_i == FT_SOLO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q     <= '0;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      for_cache_o <= 1'b0;
      for_dir_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (flit_valid_i) begin
        slots_q[cnt_q] <= flit_payload_i;
        if (is_last) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else if (cnt_q == CW'(FLITS - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (is_first) begin
          for_cache_o <= (flit_dest_i == DST_CACHE);
          for_dir_o   <= (flit_dest_i == DST_DIR);
        end
      end
    end
  end

  assign pkt_o = slots_q;

  p_tail_completes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_i && is_last) |=> done_o);
  p_done_needs_tail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(flit_valid_i && is_last));
  p_restart_slot0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_i && is_last) |=> (cnt_q == '0));
endmodule

// File: rtl/ej_filter.sv
module ej_filter
  import ej_pkg::*;
#(
  parameter int unsigned SINK = SINK_ANY
) (
  input  logic done_i,
  input  logic for_cache_i,
  input  logic for_dir_i,
  output logic enq_o
);
  generate
    if (SINK == SINK_CACHE) begin : g_cache
      logic unused_flag;
      assign unused_flag = for_dir_i;
      assign enq_o = done_i & for_cache_i;
    end else if (SINK == SINK_DIR) begin : g_dir
      logic unused_flag;
      assign unused_flag = for_cache_i;
      assign enq_o = done_i & for_dir_i;
    end else begin : g_any
      logic unused_flags;
      assign unused_flags = for_cache_i ^ for_dir_i;
      assign enq_o = done_i;
    end
  endgenerate
endmodule

// File: rtl/ej_fifo.sv
module ej_fifo #(
  parameter int unsigned W        = 32,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned AF_LEVEL = 2,
  localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OW      = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         almost_full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [OW-1:0] occ_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (occ_q != OW'(DEPTH));
  assign do_pop  = pop_i && (occ_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      occ_q <= occ_q + 1'b1;
      else if (do_pop && !do_push) occ_q <= occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign data_o        = mem_q[rd_q];
  assign empty_o       = (occ_q == '0);
  assign almost_full_o = (occ_q >= OW'(AF_LEVEL));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (occ_q != OW'(DEPTH)) || pop_i);
  p_empty_pop_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
  p_push_fills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o);
endmodule

// File: rtl/pkt_ejector.sv
module pkt_ejector
  import ej_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 8,
  parameter int unsigned FLITS     = 4,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned SINK      = SINK_ANY,
  localparam int unsigned PKT_W    = FLITS * PAYLOAD_W,
  localparam int unsigned AF_LEVEL = DEPTH - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flit_valid_i,
  input  logic [1:0]           flit_type_i,
  input  logic [1:0]           flit_dest_i,
  input  logic [PAYLOAD_W-1:0] flit_payload_i,
  output logic                 pkt_valid_o,
  output logic [PKT_W-1:0]     pkt_data_o,
  input  logic                 pkt_consumed_i,
  output logic                 stop_o
);
  logic [PKT_W-1:0] rebuilt;
  logic             done, for_cache, for_dir, enq, fifo_empty;

  ej_assembler #(.PAYLOAD_W(PAYLOAD_W), .FLITS(FLITS)) i_assembler (
    .clk_i, .rst_ni, .flit_valid_i, .flit_type_i, .flit_dest_i, .flit_payload_i,
    .pkt_o(rebuilt), .done_o(done), .for_cache_o(for_cache), .for_dir_o(for_dir)
  );

  ej_filter #(.SINK(SINK)) i_filter (
    .done_i(done), .for_cache_i(for_cache), .for_dir_i(for_dir), .enq_o(enq)
  );

  ej_fifo #(.W(PKT_W), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) i_fifo (
    .clk_i, .rst_ni, .push_i(enq), .data_i(rebuilt), .pop_i(pkt_consumed_i),
    .data_o(pkt_data_o), .empty_o(fifo_empty), .almost_full_o(stop_o)
  );

  assign pkt_valid_o = !fifo_empty;

  p_valid_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_valid_o) |-> $past(done));
endmodule

// File: tb/test_pkt_ejector.sv
module test_pkt_ejector;
  import ej_pkg::*;
  localparam int PW = 8, FL = 4, DP = 4, PKW = FL * PW;

  logic clk = 0, rst_n = 0;
  logic fv = 0;
  logic [1:0] ft = 0, fd = 0;
  logic [PW-1:0] fp = 0;
  logic [2:0] pv, cons = 0, stop;
  logic [PKW-1:0] pd [3];
  logic hold = 0, spam = 0;
  int total = 0, bad = 0;

  logic [PKW-1:0] q0[$], q1[$], q2[$];
  logic [PW-1:0] ms [FL];
  int mcnt = 0;
  logic [1:0] mdest = 0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < 3; k++) begin : g_dut
    pkt_ejector #(.PAYLOAD_W(PW), .FLITS(FL), .DEPTH(DP), .SINK(k)) i_pkt_ejector (
      .clk_i(clk), .rst_ni(rst_n), .flit_valid_i(fv), .flit_type_i(ft),
      .flit_dest_i(fd), .flit_payload_i(fp), .pkt_valid_o(pv[k]),
      .pkt_data_o(pd[k]), .pkt_consumed_i(cons[k]), .stop_o(stop[k])
    );
  end

  task automatic check(string req, logic [PKW-1:0] got, logic [PKW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int qsize(int k);
    return (k == 0) ? q0.size() : (k == 1) ? q1.size() : q2.size();
  endfunction

  function automatic logic [PKW-1:0] qpop(int k);
    if (k == 0) return q0.pop_front();
    if (k == 1) return q1.pop_front();
    return q2.pop_front();
  endfunction

  // scoreboard monitor (R8, R9)
  always @(negedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n || hold) cons[k] <= 1'b0;
      else if (spam) begin
        cons[k] <= 1'b1;
        if (pv[k]) check("R9 valid while empty", pv[k], 1'b0);
      end else if (pv[k]) begin
        if (qsize(k) == 0) check("R8 unexpected packet", pv[k], 1'b0);
        else check("R8 order/data", pd[k], qpop(k));
        cons[k] <= 1'b1;
      end else cons[k] <= 1'b0;
    end
  end

  // driver: one flit per call, starts and ends at a negedge
  task automatic flit(logic [1:0] t, logic [1:0] d, logic [PW-1:0] p);
    logic [PKW-1:0] pk;
    ft = t; fd = d; fp = p; fv = 1;
    ms[mcnt] = p;
    if (t == FT_HEAD || t == FT_SOLO) mdest = d;
    if (t == FT_TAIL || t == FT_SOLO) begin
      for (int i = 0; i < FL; i++) pk[i*PW +: PW] = ms[i];
      q0.push_back(pk);
      if (mdest == DST_CACHE) q1.push_back(pk);
      if (mdest == DST_DIR) q2.push_back(pk);
      mcnt = 0;
    end else mcnt = (mcnt + 1) % FL;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    fv = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic packet(int len, logic [1:0] d, logic [PW-1:0] base);
    if (len == 1) flit(FT_SOLO, d, base);
    else for (int i = 0; i < len; i++)
      flit(i == 0 ? FT_HEAD : (i == len - 1 ? FT_TAIL : FT_BODY), d, base + PW'(i));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 7;
    for (int i = 0; i < FL; i++) ms[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset valid", pv, 3'b000);
    check("R10 reset stop", stop, 3'b000);

    // R1, R3, R5: four-flit packet to the cache controller
    hold = 1;
    flit(FT_HEAD, DST_CACHE, 8'h20);
    flit(FT_BODY, DST_CACHE, 8'h40);
    flit(FT_BODY, DST_CACHE, 8'h60);
    flit(FT_TAIL, DST_CACHE, 8'h10);
    fv = 0;
    check("R3 not yet visible", pv, 3'b000);
    @(negedge clk);
    check("R3 visible after one more edge", pv, 3'b011);
    check("R1 slot order", pd[1], 32'h10604020);
    check("R5 dir copy drops cache packet", pv[2], 1'b0);

    // R11: single-flit packet to the directory leaves upper slots stale
    flit(FT_SOLO, DST_DIR, 8'h5a);
    idle(1);
    check("R11 stale slots", pd[2], 32'h1060405a);
    check("R5 dir copy keeps dir packet", pv[2], 1'b1);
    hold = 0;
    idle(6);

    // R4, R6: packet for neither, then a cache packet must start at slot 0
    hold = 1;
    packet(2, 2'd0, 8'h01);
    packet(4, DST_CACHE, 8'hb0);
    idle(2);
    check("R4 neither code reaches no filtered copy", pv[2], 1'b0);
    check("R6 next packet starts at slot 0", pd[1], 32'hb3b2b1b0);
    hold = 0;
    idle(6);

    // mixed lengths and destinations, consumer draining
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1103515245 + 12345;
      packet(((seed >>> 16) & 3) + 1, 2'(n % 3), 8'((seed >>> 8) & 8'hff));
      if ((n & 1) == 0) idle(1);
    end
    idle(8);
    check("R8 queues drained", 32'(qsize(0) + qsize(1) + qsize(2)), 32'd0);

    // R7: back-pressure threshold at DEPTH-2
    hold = 1;
    flit(FT_SOLO, 2'd0, 8'hc1);
    idle(1);
    check("R7 one entry no stop", stop, 3'b000);
    flit(FT_SOLO, 2'd0, 8'hc2);
    idle(1);
    check("R7 stop at two entries", stop, 3'b001);
    flit(FT_SOLO, 2'd0, 8'hc3);
    flit(FT_SOLO, 2'd0, 8'hc4);
    idle(2);
    check("R7 stop while full", stop, 3'b001);
    hold = 0;
    idle(8);
    check("R7 stop released", stop, 3'b000);
    check("R8 valid low when empty", pv, 3'b000);

    // R9: consumed strobes on empty FIFO
    spam = 1;
    idle(5);
    spam = 0;
    @(negedge clk);
    check("R9 still empty", pv, 3'b000);
    check("R9 no stop", stop, 3'b000);
    packet(3, DST_CACHE, 8'h90);
    idle(6);

    // R10: reset mid-stream
    hold = 1;
    packet(1, 2'd0, 8'h44);
    flit(FT_HEAD, DST_DIR, 8'h77);
    fv = 0;
    rst_n = 0;
    idle(2);
    q0.delete(); q1.delete(); q2.delete();
    for (int i = 0; i < FL; i++) ms[i] = '0;
    mcnt = 0; mdest = 0;
    rst_n = 1;
    @(negedge clk);
    check("R10 FIFO cleared", pv, 3'b000);
    flit(FT_SOLO, DST_CACHE, 8'h33);
    idle(1);
    check("R10 register cleared", pd[1], 32'h00000033);
    hold = 0;
    idle(6);
    check("R8 final drain", 32'(qsize(0) + qsize(1) + qsize(2)), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule